// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is a byte-wide synchronous serial port for a microcontroller-style peripheral bus. The transmitter and the receiver share one shift clock. That clock is either generated on chip from the system clock, through an optional divide-by-4 prescaler and a programmable divider, or taken from an external clock pin. Each transfer moves eight bits, least significant bit first. Output data changes on the falling edge of the shift clock, input data is sampled on the rising edge, and the clock idles high.

Software sees four byte registers. Address 0 is the data register: a write loads the transmit buffer and a read returns the receive buffer. Address 1 is status, address 2 is control, and address 3 is the divider value n. The transmit path is double buffered. If software refills the buffer before the last bit of the current byte has shifted out, the next byte follows with no gap in the clock. A control bit selects whether the transmit interrupt marks an empty buffer or a finished shift. A ready output tells the remote side when the receiver can take another byte.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register reads TBE=1 (bit 0), TSC=1 (bit 1), RBF=0 (bit 2) and OE=0 (bit 3); sclk_out is high and both interrupt outputs are low.
- R2: With control bit 2 = 0 (internal clock), sclk_out toggles once every (n+1)·P system cycles while a transfer runs, where n is the divider register (address 3) and P is 4 when control bit 3 = 1 and 1 otherwise; sclk_oe is 1 and sclk_out is high between transfers.
- R3: A write to address 0 makes TBE read 0 in the next cycle; one cycle later the byte moves into the shift register, which starts the transfer in internal-clock mode, and TBE reads 1 again.
- R4: TSC reads 0 from the moment a byte is loaded into the shift register until the eighth rising shift-clock edge of the last byte, after which it reads 1.
- R5: sdata_out presents the transmitted byte least significant bit first, with each new bit appearing at a falling edge of the shift clock.
- R6: sdata_in is sampled on each rising shift-clock edge, least significant bit first; after eight bits with control bit 0 = 1 (receive enable), the byte can be read at address 0, RBF reads 1, and rx_irq pulses for one cycle.
- R7: With control bit 4 = 0, tx_irq pulses for one cycle each time TBE returns to 1 because a byte moved into the shift register.
- R8: With control bit 4 = 1, tx_irq pulses for one cycle each time TSC becomes 1, and not when TBE becomes 1.
- R9: A read of address 0 clears RBF; rdy_out equals (receive enable AND NOT RBF).
- R10: A byte written while TSC = 0 follows the current byte on sdata_out, and the shift clock keeps its period with no gap between the two bytes.
- R11: A byte that completes while RBF = 1 sets OE (status bit 3) and leaves the receive buffer unchanged. OE clears only when a status read is followed by a data read.
- R12: With control bit 2 = 1 (external clock), sclk_oe is 0 and the synchronized edges of sclk_in drive the shifting. A loaded byte waits for the first external falling edge before its first bit is shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control, 3 divider |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (triggers read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the shift clock pin (1 in internal-clock mode) |
| sdata_in | input | 1 | Serial data input |
| sdata_out | output | 1 | Serial data output |
| rdy_out | output | 1 | Receiver ready handshake |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
A data write takes effect on the clock edge where the strobe is sampled. TBE is read as 0 at the following falling clock edge and as 1 one cycle later. In internal-clock mode the shift clock then toggles every (n+1)·P cycles. The bench records the cycle count between each pair of observed toggles and compares it with that value, so a gap between back-to-back bytes shows up as a wrong count. RBF, TSC and the interrupt pulses all update on the same edge as the eighth rising shift-clock edge. The bench reads them at the first falling system-clock edge after that edge, and counts interrupt pulses only at falling clock edges. In external mode, each edge of sclk_in reaches the logic two to three cycles late through the synchronizer. The bench therefore holds each half period of sclk_in for six cycles and samples sdata_out just before its next edge.

// File: rtl/ssp_pkg.sv
// Package: shared types and register bit positions for the serial port.
// Assumes a two-bit register address and byte-wide registers.
package ssp_pkg;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_STAT = 2'd1,
        A_CTRL = 2'd2,
        A_BAUD = 2'd3
    } ssp_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ssp_state_e;

    // control register bit positions
    localparam int CB_RX_EN   = 0;
    localparam int CB_EXT_CLK = 2;
    localparam int CB_DIV4    = 3;
    localparam int CB_IRQ_SEL = 4;

endpackage

// File: rtl/ssp_rate_gen.sv
// Rate generator: produces a one-cycle tick every (n+1)*P system cycles,
// P = PRE_RATIO when div4 is set, else 1. Held at count zero while clear
// is high so the first tick of a transfer comes a full period after start.
module ssp_rate_gen #(
    parameter int DIV_W     = 8,
    parameter int PRE_RATIO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             div4,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_en;

    // prescaler enable: every cycle, or once per PRE_RATIO cycles
    assign pre_en = div4 ? (pre_cnt == PRE_W'(PRE_RATIO - 1)) : 1'b1;
    assign tick   = pre_en && (div_cnt == div_n);

    // prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !div4 || pre_en) pre_cnt <= '0;
        else                                    pre_cnt <= pre_cnt + 1'b1;
    end

    // main divider counter, wraps at div_n
    always_ff @(posedge clk) begin
        if (!rst_n || clear) div_cnt <= '0;
        else if (pre_en)     div_cnt <= (div_cnt == div_n) ? '0 : div_cnt + 1'b1;
    end

    // R2: with the prescaler active two ticks never fall in consecutive cycles
    p_presc_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div4 && tick && PRE_RATIO > 1) |=> (!tick || !div4));

endmodule

// File: rtl/ssp_clk_sync.sv
// External clock synchronizer: STAGES-flop chain into the system clock
// domain followed by an edge detector. Idles high, matching the shift clock.
// Assumes the external clock half period exceeds STAGES+1 system cycles.
module ssp_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    // synchronizer chain plus one delay for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '1;
            prev_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], async_in};
            prev_q <= chain[STAGES-1];
        end
    end

    assign fall = prev_q && !chain[STAGES-1];
    assign rise = !prev_q && chain[STAGES-1];

    // R12: an edge is reported for a single cycle only
    p_single_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/ssp_shift_engine.sv
// Shift engine: loads the transmit byte, shifts it out LSB first on falling
// shift-clock edges and shifts in on rising edges. Tracks the clock phase in
// both modes; in internal mode each rate tick toggles the phase, in external
// mode the synchronized edges do. Reloads on the last rising edge when the
// buffer holds another byte, so consecutive bytes have no gap.
module ssp_shift_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              rate_tick,
    input  logic              ext_fall,
    input  logic              ext_rise,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              sdata_in,
    output logic              load,
    output logic              tx_done,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              running,
    output logic              sclk_int,
    output logic              sdata_out
);
    import ssp_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);

    ssp_state_e        state;
    logic [DATA_W-1:0] sh_tx;
    logic [DATA_W-1:0] sh_rx;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sclk_q;
    logic              sdo_q;
    logic              fall_ev;
    logic              rise_ev;
    logic              last_rise;

    assign running = (state == ST_RUN);

    // edge events, gated by the phase so rises before the first fall are ignored
    always_comb begin
        if (ext_mode) begin
            fall_ev = running && sclk_q && ext_fall;
            rise_ev = running && !sclk_q && ext_rise;
        end else begin
            fall_ev = running && sclk_q && rate_tick;
            rise_ev = running && !sclk_q && rate_tick;
        end
    end

    assign last_rise = rise_ev && (bit_cnt == CNT_W'(DATA_W - 1));
    assign load      = (!running && buf_full) || (last_rise && buf_full);
    assign tx_done   = last_rise && !buf_full;
    assign rx_done   = last_rise;
    assign rx_byte   = {sdata_in, sh_rx[DATA_W-1:1]};
    assign sclk_int  = sclk_q;
    assign sdata_out = sdo_q;

    // transfer state, phase and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sclk_q  <= 1'b1;
            bit_cnt <= '0;
        end else if (!running) begin
            sclk_q  <= 1'b1;
            bit_cnt <= '0;
            if (buf_full) state <= ST_RUN;
        end else if (fall_ev) begin
            sclk_q <= 1'b0;
        end else if (rise_ev) begin
            sclk_q  <= 1'b1;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_rise && !buf_full) state <= ST_IDLE;
        end
    end

    // transmit shift register and output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tx <= '0;
            sdo_q <= 1'b1;
        end else if (load) begin
            sh_tx <= buf_data;
        end else if (fall_ev) begin
            sdo_q <= sh_tx[0];
            sh_tx <= {1'b0, sh_tx[DATA_W-1:1]};
        end
    end

    // receive shift register
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_rx <= '0;
        else if (rise_ev) sh_rx <= rx_byte;
    end

    // R2: the shift clock idles high outside a transfer
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> sclk_q);

    // R5: the output bit changes only at a falling shift-clock edge
    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(sdo_q));

    // R3: a load always leaves the engine running
    p_run_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> running);

endmodule

// File: rtl/sync_serial_port.sv
// Clock-synchronous serial port top: register file on a simple byte bus,
// double-buffered transmit, receive buffer with overrun detection, interrupt
// pulses and ready handshake. Assumes one-cycle bus strobes; read data is
// combinational from the address, read side effects follow the bus_rd strobe.
module sync_serial_port #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int PRE_RATIO   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdata_in,
    output logic              sdata_out,
    output logic              rdy_out,
    output logic              tx_irq,
    output logic              rx_irq
);
    import ssp_pkg::*;

    ssp_addr_e         addr;
    logic [DATA_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  baud_q;
    logic [DATA_W-1:0] tx_buf;
    logic [DATA_W-1:0] rx_buf;
    logic              buf_full, tsc_q, rbf_q, oe_q, stat_seen_q;
    logic              tx_irq_q, rx_irq_q;
    logic              wr_data, rd_data, rd_stat;
    logic              ext_mode, rx_en, irq_sel;
    logic              load, tx_done, rx_done, running, sclk_int;
    logic              rate_tick, ext_fall, ext_rise;
    logic [DATA_W-1:0] rx_byte;
    logic              store_ev, ovr_ev;

    assign addr     = ssp_addr_e'(bus_addr);
    assign wr_data  = bus_wr && (addr == A_DATA);
    assign rd_data  = bus_rd && (addr == A_DATA);
    assign rd_stat  = bus_rd && (addr == A_STAT);
    assign ext_mode = ctrl_q[CB_EXT_CLK];
    assign rx_en    = ctrl_q[CB_RX_EN];
    assign irq_sel  = ctrl_q[CB_IRQ_SEL];
    assign store_ev = rx_done && rx_en;
    assign ovr_ev   = store_ev && rbf_q && !rd_data;

    ssp_rate_gen #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!running),
        .div4  (ctrl_q[CB_DIV4]),
        .div_n (baud_q),
        .tick  (rate_tick)
    );

    ssp_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .fall     (ext_fall),
        .rise     (ext_rise)
    );

    ssp_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .rate_tick (rate_tick),
        .ext_fall  (ext_fall),
        .ext_rise  (ext_rise),
        .buf_full  (buf_full),
        .buf_data  (tx_buf),
        .sdata_in  (sdata_in),
        .load      (load),
        .tx_done   (tx_done),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .running   (running),
        .sclk_int  (sclk_int),
        .sdata_out (sdata_out)
    );

    // control and divider registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            baud_q <= '0;
        end else if (bus_wr) begin
            if (addr == A_CTRL) ctrl_q <= bus_wdata;
            if (addr == A_BAUD) baud_q <= bus_wdata[DIV_W-1:0];
        end
    end

    // transmit buffer and its full flag (TBE is the inverse)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            buf_full <= 1'b0;
        end else if (wr_data) begin
            tx_buf   <= bus_wdata;
            buf_full <= 1'b1;
        end else if (load) begin
            buf_full <= 1'b0;
        end
    end

    // transmit shift complete flag
    always_ff @(posedge clk) begin
        if (!rst_n)       tsc_q <= 1'b1;
        else if (load)    tsc_q <= 1'b0;
        else if (tx_done) tsc_q <= 1'b1;
    end

    // receive buffer and full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
            rbf_q  <= 1'b0;
        end else if (store_ev && !ovr_ev) begin
            rx_buf <= rx_byte;
            rbf_q  <= 1'b1;
        end else if (rd_data) begin
            rbf_q <= 1'b0;
        end
    end

    // overrun flag, cleared by a status read followed by a data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q        <= 1'b0;
            stat_seen_q <= 1'b0;
        end else begin
            if (ovr_ev)                        oe_q <= 1'b1;
            else if (rd_data && stat_seen_q)   oe_q <= 1'b0;
            if (rd_data)                       stat_seen_q <= 1'b0;
            else if (rd_stat && oe_q)          stat_seen_q <= 1'b1;
        end
    end

    // interrupt pulses, aligned with the flag that caused them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq_q <= 1'b0;
            rx_irq_q <= 1'b0;
        end else begin
            tx_irq_q <= irq_sel ? tx_done : (load && !wr_data);
            rx_irq_q <= store_ev && !ovr_ev;
        end
    end

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_DATA: bus_rdata = rx_buf;
            A_STAT: bus_rdata = DATA_W'({oe_q, rbf_q, tsc_q, !buf_full});
            A_CTRL: bus_rdata = ctrl_q;
            A_BAUD: bus_rdata = DATA_W'(baud_q);
            default: bus_rdata = '0;
        endcase
    end

    assign sclk_out = ext_mode ? 1'b1 : sclk_int;
    assign sclk_oe  = !ext_mode;
    assign rdy_out  = rx_en && !rbf_q;
    assign tx_irq   = tx_irq_q;
    assign rx_irq   = rx_irq_q;

    // R3: a data write always leaves TBE at 0 in the next cycle
    p_tbe_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> buf_full);

    // R4: TSC stays low while a byte is shifting
    p_tsc_low_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !tsc_q);

    // R6: the receive interrupt is seen together with a full buffer
    p_rx_irq_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rbf_q);

    // R7: with TBE selected the transmit interrupt coincides with TBE = 1
    p_tx_irq_tbe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !$past(irq_sel)) |-> !buf_full);

    // R8: with TSC selected the transmit interrupt coincides with TSC = 1
    p_tx_irq_tsc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && $past(irq_sel)) |-> tsc_q);

    // R11: overrun can only rise while the receive buffer is full
    p_oe_needs_rbf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> rbf_q);

endmodule

// File: tb/sync_serial_port_test.sv
// Directed bench for the serial port: one task per scenario.
module sync_serial_port_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk_in = 1'b1;
    logic       sclk_out, sclk_oe;
    logic       sdata_in = 1'b0;
    logic       sdata_out, rdy_out, tx_irq, rx_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int tx_irq_cnt = 0;
    int rx_irq_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
        .sdata_in(sdata_in), .sdata_out(sdata_out), .rdy_out(rdy_out),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // interrupt pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && tx_irq) tx_irq_cnt++;
        if (rst_n && rx_irq) rx_irq_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] d);
        bus_addr = 2'd1;
        #1 d = bus_rdata;
    endtask

    // act as the remote side of an internally clocked transfer
    task automatic serve_int(input int nbits, input logic [15:0] rxv, input int period,
                             output logic [15:0] txv, output int bad);
        int k = 0;
        int since = 0;
        int guard = 0;
        bit first = 1'b1;
        logic prev;
        prev = sclk_out; txv = '0; bad = 0;
        while (k < nbits && guard < 20000) begin
            @(negedge clk);
            guard++; since++;
            if (sclk_out !== prev) begin
                if (!first && since != period) bad++;
                first = 1'b0; since = 0;
                if (!sclk_out) begin
                    txv[k] = sdata_out;
                    sdata_in = rxv[k];
                end else begin
                    k++;
                end
                prev = sclk_out;
            end
        end
        if (guard >= 20000) bad++;
    endtask

    task automatic t_reset();
        logic [7:0] st;
        peek_status(st);
        check(st == 8'h03, "R1 status", st, 8'h03);
        check(sclk_out == 1'b1 && sclk_oe == 1'b1, "R1 sclk idle", {sclk_out, sclk_oe}, 2'b11);
        check(!tx_irq && !rx_irq && !rdy_out, "R1 irq/rdy low", {tx_irq, rx_irq, rdy_out}, 0);
    endtask

    task automatic t_basic();
        logic [7:0] st;
        logic [15:0] txv;
        int bad;
        int tx0;
        bus_write(2'd2, 8'h01);
        bus_write(2'd3, 8'd2);
        check(rdy_out == 1'b1, "R9 rdy when empty", rdy_out, 1);
        tx0 = tx_irq_cnt;
        bus_write(2'd0, 8'hA5);
        peek_status(st);
        check(st[0] == 1'b0, "R3 TBE cleared", st[0], 0);
        @(negedge clk);
        peek_status(st);
        check(st[0] == 1'b1, "R3 TBE set at load", st[0], 1);
        check(st[1] == 1'b0, "R4 TSC cleared at load", st[1], 0);
        serve_int(8, 16'h003C, 3, txv, bad);
        check(bad == 0, "R2 period n=2", bad, 0);
        check(txv[7:0] == 8'hA5, "R5 tx LSB first", txv[7:0], 8'hA5);
        peek_status(st);
        check(st[2:1] == 2'b11, "R6/R4 RBF and TSC set", st[2:1], 2'b11);
        check(rdy_out == 1'b0, "R9 rdy low when full", rdy_out, 0);
        @(negedge clk);
        check(rx_irq_cnt == 1, "R6 rx_irq once", rx_irq_cnt, 1);
        check(tx_irq_cnt - tx0 == 1, "R7 tx_irq on TBE", tx_irq_cnt - tx0, 1);
        check(sclk_out == 1'b1, "R2 idle high", sclk_out, 1);
    endtask

    task automatic t_overrun();
        logic [7:0] st, d;
        logic [15:0] txv;
        int bad;
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        serve_int(8, 16'h0055, 3, txv, bad);
        @(negedge clk);
        peek_status(st);
        check(st[3] == 1'b1, "R11 OE set", st[3], 1);
        bus_read(2'd0, d);
        check(d == 8'h3C, "R11 buffer kept / R6 rx data", d, 8'h3C);
        peek_status(st);
        check(st[2] == 1'b0, "R9 read clears RBF", st[2], 0);
        check(st[3] == 1'b1, "R11 OE kept without status read", st[3], 1);
        bus_read(2'd1, st);
        bus_read(2'd0, d);
        peek_status(st);
        check(st[3] == 1'b0, "R11 OE cleared", st[3], 0);
    endtask

    task automatic t_presc();
        logic [15:0] txv;
        int bad;
        bus_write(2'd2, 8'h08);
        bus_write(2'd3, 8'd1);
        bus_write(2'd0, 8'h81);
        serve_int(8, 16'h0000, 8, txv, bad);
        check(bad == 0, "R2 period with prescaler", bad, 0);
        check(txv[7:0] == 8'h81, "R5 tx with prescaler", txv[7:0], 8'h81);
    endtask

    task automatic t_b2b();
        logic [7:0] st;
        logic [15:0] txv;
        int bad;
        int tx0;
        bus_write(2'd2, 8'h10);
        bus_write(2'd3, 8'd3);
        tx0 = tx_irq_cnt;
        bus_write(2'd0, 8'h5A);
        bus_write(2'd0, 8'hC3);
        serve_int(8, 16'h0000, 4, txv, bad);
        peek_status(st);
        check(st[1] == 1'b0, "R10 TSC low between bytes", st[1], 0);
        serve_int(8, 16'h0000, 4, txv, bad);
        check(bad == 0, "R10 no gap at byte boundary", bad, 0);
        check(txv[7:0] == 8'hC3, "R10 second byte", txv[7:0], 8'hC3);
        @(negedge clk);
        peek_status(st);
        check(st[1] == 1'b1, "R4 TSC set at end", st[1], 1);
        check(tx_irq_cnt - tx0 == 1, "R8 single tx_irq on TSC", tx_irq_cnt - tx0, 1);
    endtask

    task automatic t_ext();
        logic [7:0] st, d;
        logic [7:0] txb;
        bus_write(2'd2, 8'h05);
        check(sclk_oe == 1'b0, "R12 clock not driven", sclk_oe, 0);
        bus_write(2'd0, 8'h96);
        repeat (10) @(negedge clk);
        peek_status(st);
        check(st[1:0] == 2'b01, "R12 loaded, waits for edge", st[1:0], 2'b01);
        txb = '0;
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
            txb[i] = sdata_out;
            sdata_in = 8'h69 >> i;
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        check(txb == 8'h96, "R12 external tx", txb, 8'h96);
        bus_read(2'd0, d);
        check(d == 8'h69, "R12 external rx", d, 8'h69);
        peek_status(st);
        check(st[1] == 1'b1, "R12 TSC after external byte", st[1], 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_overrun();
        t_presc();
        t_b2b();
        t_ext();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule